// File: doc/BRIEF.md
# Audio Source Select and Auto-Mute Controller

This synchronous controller sits beside the decoder of a digital stereo sound receiver. Every frame it chooses which audio source drives the output switch: the decoded digital audio, a backup mono analog input, or a stereo analog input pair. It also decides when the two decoded-audio converters are muted. It reads the decoder's status: frame alignment lock, error rate above limit, and content type. It also reads a policy flag that allows fallback to the backup source, two force bits from a control register, a test override that removes the mute, and an option that routes the single mono channel to both converters.

Failures of reception are debounced over whole frames. The backup mono source is taken only after a programmable number of consecutive bad frames. The decoded audio comes back only after a programmable run of good frames. Converter mutes react at the first bad frame boundary. All outputs are registered and change only on the clock edge that carries the frame-boundary strobe, so no switch or mute moves in the middle of a frame.

Top module: `audio_fallback_ctrl`

## Requirements
- R1: While reset is asserted and just after it, `src_sel` is 0 (decoded audio), and `mute_left`, `mute_right` and `mute_matrix` are all 1.
- R2: All four outputs change only on a rising clock edge at which `frame_tick` is 1. With `frame_tick` low they hold, whatever the other inputs do.
- R3: `force_sel` = 2'b01 (bit 0 is the mono force, bit 1 is the stereo force) gives `src_sel` = 1 (mono analog input), whatever the reception state.
- R4: `force_sel` = 2'b10 gives `src_sel` = 2 (stereo analog inputs), whatever the reception state.
- R5: With `force_sel` 2'b00 or 2'b11 (automatic mode), good reception and audio content, `src_sel` = 0.
- R6: In automatic mode, `content` = 3 (data only) gives `src_sel` = 1, and both converters are muted.
- R7: A frame is bad when `frame_lock` is 0 or `err_over` is 1. With `reserve_en` = 1 in automatic mode, `src_sel` becomes 1 at the FAIL_FRAMES-th consecutive bad strobe. A shorter or interrupted run leaves the selection unchanged.
- R8: Once a failure is confirmed and `reserve_en` = 0, automatic mode keeps the previous `src_sel`.
- R9: A confirmed failure clears only after GOOD_FRAMES consecutive good strobes. Until then, automatic mode with `reserve_en` = 1 stays on source 1.
- R10: At any strobe where the frame is bad, both converter mutes are set at once, with no debounce.
- R11: `content` = 1 (first mono channel only) mutes the right converter and not the left one, unless `mono_both` = 1. Content codes 0 (stereo) and 2 (dual mono) mute neither.
- R12: `test_unmute` = 1 clears both converter mutes despite any mute condition.
- R13: `mute_matrix` is 1 exactly when `src_sel` = 0 and the left converter is muted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_tick | input | 1 | Frame-boundary strobe, one cycle wide |
| frame_lock | input | 1 | Decoder frame alignment achieved |
| err_over | input | 1 | Bit error rate above the limit |
| content | input | 2 | Content type: 0 stereo, 1 single mono, 2 dual mono, 3 data only |
| reserve_en | input | 1 | Allows fallback to the mono analog input |
| force_sel | input | 2 | Bit 0 forces mono input, bit 1 forces stereo input |
| test_unmute | input | 1 | Test override that clears converter mutes |
| mono_both | input | 1 | Route the single mono channel to both converters |
| src_sel | output | 2 | Switch selection: 0 decoded, 1 mono input, 2 stereo input |
| mute_left | output | 1 | Left converter mute |
| mute_right | output | 1 | Right converter mute |
| mute_matrix | output | 1 | Matrix mute: decoded path selected but silent |

## Verification
Assertions check on every cycle the properties that hold edge by edge: outputs stay still between strobes, force codes win, data-only content selects mono, the selection is held without a reserve, mutes react to bad frames, the single-mono right mute, the test override, and the matrix-mute relation. Only the bench's scenarios can show the history-dependent behaviour. This covers fallback at exactly the FAIL_FRAMES-th bad frame, the restart of a run that a good frame interrupts, the return to decoded audio after exactly GOOD_FRAMES good frames, and the reset values observed at the ports.

// File: rtl/afc_pkg.sv
package afc_pkg;

   typedef enum logic [1:0] {
      SRC_DECODED = 2'd0,
      SRC_MONO_IN = 2'd1,
      SRC_STEREO_IN = 2'd2
   } src_e;

   typedef enum logic [1:0] {
      CT_STEREO = 2'd0,
      CT_MONO1  = 2'd1,
      CT_DUAL   = 2'd2,
      CT_DATA   = 2'd3
   } content_e;

   localparam logic [1:0] FORCE_MONO   = 2'b01;
   localparam logic [1:0] FORCE_STEREO = 2'b10;

endpackage

// File: rtl/afc_persist.sv
module afc_persist #(
   parameter int unsigned FAIL_FRAMES = 3,
   parameter int unsigned GOOD_FRAMES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic upd,
   input  logic bad_now,
   output logic confirmed_q,
   output logic confirmed_nxt
);
   localparam int unsigned MAXF = (FAIL_FRAMES > GOOD_FRAMES) ? FAIL_FRAMES : GOOD_FRAMES;
   localparam int unsigned CW   = (MAXF < 2) ? 1 : $clog2(MAXF);
   localparam logic [CW-1:0] FAIL_LIM = CW'(FAIL_FRAMES - 1);
   localparam logic [CW-1:0] GOOD_LIM = CW'(GOOD_FRAMES - 1);

   if (FAIL_FRAMES < 1) begin : g_bad_fail
      $error("FAIL_FRAMES must be at least 1");
   end
   if (GOOD_FRAMES < 1) begin : g_bad_good
      $error("GOOD_FRAMES must be at least 1");
   end

   logic [CW-1:0] run_q, run_nxt;
   logic [CW-1:0] lim;

   always_comb begin
      lim           = confirmed_q ? GOOD_LIM : FAIL_LIM;
      run_nxt       = run_q;
      confirmed_nxt = confirmed_q;
      if (upd) begin
         if (bad_now != confirmed_q) begin
            if (run_q == lim) begin
               confirmed_nxt = bad_now;
               run_nxt       = '0;
            end else begin
               run_nxt = run_q + 1'b1;
            end
         end else begin
            run_nxt = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q       <= '0;
         confirmed_q <= 1'b0;
      end else begin
         run_q       <= run_nxt;
         confirmed_q <= confirmed_nxt;
      end
   end

   // R7 / R9: the run counter never passes the larger window
   p_run_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run_q < CW'(MAXF));

   // R7: the state moves only on an update
   p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(confirmed_q));

endmodule

// File: rtl/afc_select.sv
module afc_select
   import afc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       upd,
   input  logic [1:0] force_sel,
   input  logic       data_only,
   input  logic       fail_nxt,
   input  logic       reserve_en,
   output src_e       sel_q,
   output src_e       sel_nxt
);
   logic auto_mode;

   always_comb begin
      auto_mode = (force_sel != FORCE_MONO) && (force_sel != FORCE_STEREO);
      sel_nxt   = sel_q;
      if (upd) begin
         if (force_sel == FORCE_MONO) begin
            sel_nxt = SRC_MONO_IN;
         end else if (force_sel == FORCE_STEREO) begin
            sel_nxt = SRC_STEREO_IN;
         end else if (data_only) begin
            sel_nxt = SRC_MONO_IN;
         end else if (fail_nxt) begin
            sel_nxt = reserve_en ? SRC_MONO_IN : sel_q;
         end else begin
            sel_nxt = SRC_DECODED;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= SRC_DECODED;
      else        sel_q <= sel_nxt;
   end

   p_force_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
      upd && force_sel == 2'b01 |=> sel_q == SRC_MONO_IN);

   p_force_stereo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      upd && force_sel == 2'b10 |=> sel_q == SRC_STEREO_IN);

   p_data_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      upd && auto_mode && data_only |=> sel_q == SRC_MONO_IN);

   p_hold_no_reserve_r8: assert property (@(posedge clk) disable iff (!rst_n)
      upd && auto_mode && !data_only && fail_nxt && !reserve_en |=> $stable(sel_q));

   p_sel_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(sel_q));

endmodule

// File: rtl/afc_mute.sv
module afc_mute #(
   parameter bit MONO_RIGHT_MUTE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic upd,
   input  logic bad_now,
   input  logic data_only,
   input  logic mono1_only,
   input  logic mono_both,
   input  logic test_unmute,
   input  logic dec_sel_nxt,
   output logic mute_l_q,
   output logic mute_r_q,
   output logic mute_mtx_q
);
   logic both_cond, right_cond;
   logic ml_nxt, mr_nxt, mx_nxt;

   always_comb both_cond = bad_now || data_only;

   if (MONO_RIGHT_MUTE) begin : g_right_mono
      always_comb right_cond = mono1_only && !mono_both;
   end else begin : g_right_plain
      always_comb right_cond = 1'b0;
   end

   always_comb begin
      ml_nxt = mute_l_q;
      mr_nxt = mute_r_q;
      mx_nxt = mute_mtx_q;
      if (upd) begin
         ml_nxt = !test_unmute && both_cond;
         mr_nxt = !test_unmute && (both_cond || right_cond);
         mx_nxt = dec_sel_nxt && ml_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mute_l_q   <= 1'b1;
         mute_r_q   <= 1'b1;
         mute_mtx_q <= 1'b1;
      end else begin
         mute_l_q   <= ml_nxt;
         mute_r_q   <= mr_nxt;
         mute_mtx_q <= mx_nxt;
      end
   end

   p_test_unmute_r12: assert property (@(posedge clk) disable iff (!rst_n)
      upd && test_unmute |=> !mute_l_q && !mute_r_q);

   p_bad_mutes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      upd && !test_unmute && bad_now |=> mute_l_q && mute_r_q);

   p_mono_right_r11: assert property (@(posedge clk) disable iff (!rst_n)
      upd && !test_unmute && !bad_now && !data_only && mono1_only && !mono_both
      |=> mute_r_q && !mute_l_q);

   p_mute_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(mute_l_q) && $stable(mute_r_q) && $stable(mute_mtx_q));

endmodule

// File: rtl/audio_fallback_ctrl.sv
module audio_fallback_ctrl
   import afc_pkg::*;
#(
   parameter int unsigned FAIL_FRAMES = 3,
   parameter int unsigned GOOD_FRAMES = 2,
   parameter bit          FRAME_SYNC  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_tick,
   input  logic       frame_lock,
   input  logic       err_over,
   input  logic [1:0] content,
   input  logic       reserve_en,
   input  logic [1:0] force_sel,
   input  logic       test_unmute,
   input  logic       mono_both,
   output logic [1:0] src_sel,
   output logic       mute_left,
   output logic       mute_right,
   output logic       mute_matrix
);
   logic upd, bad_now, data_only, mono1_only;
   logic fail_q, fail_nxt;
   src_e sel_q, sel_nxt;

   if (FRAME_SYNC) begin : g_frame_upd
      always_comb upd = frame_tick;
   end else begin : g_cycle_upd
      always_comb upd = 1'b1;
   end

   always_comb begin
      bad_now    = !frame_lock || err_over;
      data_only  = content_e'(content) == CT_DATA;
      mono1_only = content_e'(content) == CT_MONO1;
   end

   afc_persist #(
      .FAIL_FRAMES(FAIL_FRAMES),
      .GOOD_FRAMES(GOOD_FRAMES)
   ) i_persist (
      .clk          (clk),
      .rst_n        (rst_n),
      .upd          (upd),
      .bad_now      (bad_now),
      .confirmed_q  (fail_q),
      .confirmed_nxt(fail_nxt)
   );

   afc_select i_select (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd       (upd),
      .force_sel (force_sel),
      .data_only (data_only),
      .fail_nxt  (fail_nxt),
      .reserve_en(reserve_en),
      .sel_q     (sel_q),
      .sel_nxt   (sel_nxt)
   );

   afc_mute i_mute (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd        (upd),
      .bad_now    (bad_now),
      .data_only  (data_only),
      .mono1_only (mono1_only),
      .mono_both  (mono_both),
      .test_unmute(test_unmute),
      .dec_sel_nxt(sel_nxt == SRC_DECODED),
      .mute_l_q   (mute_left),
      .mute_r_q   (mute_right),
      .mute_mtx_q (mute_matrix)
   );

   always_comb src_sel = sel_q;

   // R13: matrix mute relates the selection register and the mute register
   p_matrix_rel_r13: assert property (@(posedge clk) disable iff (!rst_n)
      mute_matrix == (sel_q == SRC_DECODED && mute_left));

   // R9: a confirmed failure in automatic mode with reserve never shows decoded audio
   p_no_decoded_in_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
      upd && fail_nxt && reserve_en && force_sel != 2'b01 && force_sel != 2'b10
      |=> src_sel == 2'd1);

   // R1: the selection register is a legal code
   p_sel_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      src_sel != 2'd3);

endmodule

// File: tb/test_audio_fallback_ctrl.sv
module test_audio_fallback_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_tick = 1'b0;
   logic       frame_lock = 1'b1;
   logic       err_over = 1'b0;
   logic [1:0] content = 2'd0;
   logic       reserve_en = 1'b1;
   logic [1:0] force_sel = 2'b00;
   logic       test_unmute = 1'b0;
   logic       mono_both = 1'b0;
   logic [1:0] src_sel;
   logic       mute_left, mute_right, mute_matrix;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   audio_fallback_ctrl #(.FAIL_FRAMES(3), .GOOD_FRAMES(2)) i_audio_fallback_ctrl (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .frame_lock(frame_lock),
      .err_over(err_over), .content(content), .reserve_en(reserve_en),
      .force_sel(force_sel), .test_unmute(test_unmute), .mono_both(mono_both),
      .src_sel(src_sel), .mute_left(mute_left), .mute_right(mute_right),
      .mute_matrix(mute_matrix)
   );

   // {lock, err, content[1:0], reserve, force[1:0], unmute, mono_both,
   //  exp_sel[1:0], exp_ml, exp_mr, exp_mx}
   localparam int NV = 28;
   localparam logic [13:0] VEC [NV] = '{
      14'b1_0_00_1_00_0_0_00_0_0_0,  // 0  R5
      14'b1_0_01_1_00_0_0_00_0_1_0,  // 1  R11
      14'b1_0_01_1_00_0_1_00_0_0_0,  // 2  R11
      14'b1_0_10_1_00_0_0_00_0_0_0,  // 3  R5
      14'b0_0_00_1_00_0_0_00_1_1_1,  // 4  R10
      14'b0_0_00_1_00_0_0_00_1_1_1,  // 5  R7
      14'b0_0_00_1_00_0_0_01_1_1_0,  // 6  R7
      14'b1_0_00_1_00_0_0_01_0_0_0,  // 7  R9
      14'b1_0_00_1_00_0_0_00_0_0_0,  // 8  R9
      14'b1_1_00_0_00_0_0_00_1_1_1,  // 9  R10
      14'b1_1_00_0_00_0_0_00_1_1_1,  // 10 R10
      14'b1_1_00_0_00_0_0_00_1_1_1,  // 11 R8
      14'b1_1_00_0_10_0_0_10_1_1_0,  // 12 R4
      14'b1_1_00_0_00_0_0_10_1_1_0,  // 13 R8
      14'b1_1_00_1_00_0_0_01_1_1_0,  // 14 R7
      14'b1_1_00_1_00_1_0_01_0_0_0,  // 15 R12
      14'b1_0_00_1_01_0_0_01_0_0_0,  // 16 R3
      14'b1_0_00_1_11_0_0_00_0_0_0,  // 17 R9
      14'b1_0_11_1_00_0_0_01_1_1_0,  // 18 R6
      14'b1_0_11_1_10_0_0_10_1_1_0,  // 19 R4
      14'b1_0_11_1_00_1_0_01_0_0_0,  // 20 R12
      14'b1_0_00_1_00_0_0_00_0_0_0,  // 21 R5
      14'b1_0_00_1_01_0_0_01_0_0_0,  // 22 R3
      14'b0_0_00_1_00_0_0_00_1_1_1,  // 23 R13
      14'b1_0_00_1_00_0_0_00_0_0_0,  // 24 R7
      14'b0_0_00_1_00_0_0_00_1_1_1,  // 25 R7
      14'b0_0_00_1_00_0_0_00_1_1_1,  // 26 R7
      14'b0_0_00_1_00_0_0_01_1_1_0   // 27 R7
   };

   function automatic string row_tag(input int i);
      case (i)
         0, 3, 21:              return "R5";
         1, 2:                  return "R11";
         4, 9, 10:              return "R10";
         7, 8, 17:              return "R9";
         11, 13:                return "R8";
         12, 19:                return "R4";
         15, 20:                return "R12";
         16, 22:                return "R3";
         18:                    return "R6";
         23:                    return "R13";
         default:               return "R7";
      endcase
   endfunction

   task automatic check(input string tag, input logic [1:0] es,
                        input logic eml, input logic emr, input logic emx);
      n_checks++;
      if (src_sel !== es || mute_left !== eml || mute_right !== emr || mute_matrix !== emx) begin
         n_fail++;
         $display("FAIL %s: got sel=%0d ml=%0b mr=%0b mx=%0b, expected sel=%0d ml=%0b mr=%0b mx=%0b",
                  tag, src_sel, mute_left, mute_right, mute_matrix, es, eml, emr, emx);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         summary();
      end
   end

   initial begin
      // R1: values during reset
      repeat (3) @(negedge clk);
      check("R1", 2'd0, 1'b1, 1'b1, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 2'd0, 1'b1, 1'b1, 1'b1);

      for (int i = 0; i < NV; i++) begin
         {frame_lock, err_over, content, reserve_en, force_sel, test_unmute, mono_both} = VEC[i][13:5];
         frame_tick = 1'b1;
         @(negedge clk);
         frame_tick = 1'b0;
         check(row_tag(i), VEC[i][4:3], VEC[i][2], VEC[i][1], VEC[i][0]);
      end

      // R2: inputs move without a strobe; outputs hold (sel 1, mutes 1,1, matrix 0)
      force_sel   = 2'b10;
      frame_lock  = 1'b1;
      test_unmute = 1'b1;
      content     = 2'd1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check("R2", 2'd1, 1'b1, 1'b1, 1'b0);
      end

      // R1: reset in the middle of a run
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", 2'd0, 1'b1, 1'b1, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 2'd0, 1'b1, 1'b1, 1'b1);

      done = 1'b1;
      summary();
   end

endmodule